// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block watches the first six bytes of every received Ethernet frame and decides from them whether the frame is kept or dropped. Bytes arrive one per handshake on a byte-wide valid/ready stream. A start-of-frame flag marks the first byte of each frame. The destination address is captured from these bytes. A reflected CRC-32 is built over the same bytes, one byte per cycle. When the sixth byte has been taken, the address is judged against several rules:

- a bank of perfect-match unicast slots;
- a 64-bit multicast hash table;
- the broadcast address;
- four mode bits held in a control register.

A plain register write port loads the slots, the two hash words and the control bits. The stream input never applies back-pressure, so `s_ready` is held high. The filter only observes the stream, and a stalled upstream simply sends fewer bytes per cycle. The verdict is a one-cycle valid pulse, `dec_valid`, together with a level, `dec_accept`. The level stays put until the next frame starts.

Top module: `rx_da_filter`

## Requirements
- R1: `s_ready` is always 1. A byte is taken on every clock edge where `s_valid` is 1, and the byte taken with `s_sof`=1 is destination byte 0. A cycle with `s_valid`=0 takes nothing. Bytes taken after reset but before the first `s_sof` are ignored. A `s_sof` in the middle of a frame restarts the count at byte 0.
- R2: Let the sixth destination byte (byte 5) be taken at edge E. Then `dec_valid` is 1 for exactly one cycle, starting at edge E+1, unless a new `s_sof` byte is taken at edge E+1. Bytes after byte 5 have no effect on the decision.
- R3: `dec_accept` takes its new value when `dec_valid` rises. It is cleared to 0 when an `s_sof` byte is taken, and it is otherwise unchanged. An `s_sof` taken at edge E+1 wins, so no decision is produced for the earlier frame.
- R4: When control bit 0 (promiscuous) is 1, every decision is accept.
- R5: When control bit 3 (receive-all) is 1, every decision is accept.
- R6: The destination FF:FF:FF:FF:FF:FF is always accepted.
- R7: A frame is multicast when bit 0 of destination byte 0 is 1. When control bit 1 (pass-all-multicast) is 1, every multicast frame is accepted.
- R8: The hash index is built in four steps:
  - form the reflected CRC-32 (polynomial 0xEDB88320, initial value all ones, each byte taken least significant bit first) over the six bytes;
  - complement it;
  - bit-reverse it;
  - take the top 6 bits as the index.
  Index bit 5 selects the word: the high hash word at address 0x02 when it is 1, the low word at address 0x01 when it is 0. Index bits 4:0 pick the bit within that word. With control bit 2 (hash-multicast) set, a multicast frame is accepted only if that bit is 1. A multicast frame is dropped when neither bit 1 nor bit 2 is set.
- R9: There are 16 slots. Slot n has a low register at address 0x10+2n, holding destination bytes 0..3 with byte 0 in bits 7:0. Its high register at address 0x11+2n holds bytes 4..5 in bits 15:0 and the enable in bit 31. A unicast frame is accepted only if it equals an enabled slot. A disabled slot never matches.
- R10: After reset, `dec_valid` and `dec_accept` are 0, and all control bits, hash words and slots, including their enables, are 0.
- R11: When `cfg_we` is 1 at an edge, `cfg_wdata` is written to `cfg_addr` at that edge. A decision formed at that same edge still uses the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Receive byte valid |
| s_ready | output | 1 | Always 1, no back-pressure |
| s_sof | input | 1 | Marks the first byte of a frame |
| s_data | input | 8 | Receive byte |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register address (0x00 control, 0x01/0x02 hash, 0x10.. slots) |
| cfg_wdata | input | 32 | Register write data |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Decision level, 1 = accept |

## Verification
Two functions can fall on the same edge.

- **New frame against pending decision.** The start of a new frame can arrive on the very edge where the previous frame's decision would be registered. The bench provokes this by sending the next `s_sof` byte in the cycle right after a sixth byte. The bench's reference model expects the restart to win: no strobe, and the level cleared.
- **Register write against decision.** A register write can land on the decision edge itself. The bench provokes this by turning on promiscuous mode in that cycle. The bench then expects the drop that the old settings give, followed by an accept on the next frame.

Both cases are judged by the cycle-by-cycle comparison against the model.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef struct packed {
    logic rx_all;   // bit 3
    logic hash_mc;  // bit 2
    logic pass_mc;  // bit 1
    logic promisc;  // bit 0
  } filt_ctrl_t;

  localparam int unsigned REG_CTRL    = 0;
  localparam int unsigned REG_HASH_LO = 1;
  localparam int unsigned REG_HASH_HI = 2;
  localparam int unsigned REG_SLOT0   = 16;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

  // one byte of reflected CRC-32, data bits fed lsb first
  function automatic logic [31:0] crc_step(input logic [31:0] cur, input logic [7:0] d);
    logic [31:0] c;
    c = cur;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ d[i]) c = (c >> 1) ^ CRC_POLY_REFL;
      else             c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/rxf_cfg_bank.sv
module rxf_cfg_bank
  import rxf_pkg::*;
#(
  parameter int NSLOT  = 16,
  parameter int ADDR_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [ADDR_W-1:0]       cfg_addr,
  input  logic [31:0]             cfg_wdata,
  output filt_ctrl_t              ctrl,
  output logic [31:0]             hash_lo,
  output logic [31:0]             hash_hi,
  output logic [NSLOT-1:0][47:0]  slot_addr,
  output logic [NSLOT-1:0]        slot_en
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
  localparam logic [ADDR_W-1:0] A_HLO  = ADDR_W'(REG_HASH_LO);
  localparam logic [ADDR_W-1:0] A_HHI  = ADDR_W'(REG_HASH_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      hash_lo <= '0;
      hash_hi <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == A_CTRL) ctrl    <= filt_ctrl_t'(cfg_wdata[3:0]);
      if (cfg_addr == A_HLO)  hash_lo <= cfg_wdata;
      if (cfg_addr == A_HHI)  hash_hi <= cfg_wdata;
    end
  end

  for (genvar n = 0; n < NSLOT; n++) begin : g_slot
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(REG_SLOT0 + 2 * n);
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(REG_SLOT0 + 2 * n + 1);
    logic [47:0] addr_q;
    logic        en_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q <= '0;
        en_q   <= 1'b0;
      end else if (cfg_we) begin
        if (cfg_addr == A_LO) addr_q[31:0] <= cfg_wdata;
        if (cfg_addr == A_HI) begin
          addr_q[47:32] <= cfg_wdata[15:0];
          en_q          <= cfg_wdata[31];
        end
      end
    end
    assign slot_addr[n] = addr_q;
    assign slot_en[n]   = en_q;
  end

endmodule

// File: rtl/rxf_da_capture.sv
module rxf_da_capture
  import rxf_pkg::*;
#(
  parameter int NBYTES = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  take,
  input  logic                  sof,
  input  logic [7:0]            data,
  output logic [8*NBYTES-1:0]   da,
  output logic [31:0]           crc,
  output logic                  done
);

  localparam int CW = $clog2(NBYTES + 1);
  localparam logic [CW-1:0] LAST = CW'(NBYTES - 1);
  localparam logic [CW-1:0] FULL = CW'(NBYTES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      da   <= '0;
      crc  <= '1;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (take && sof) begin
        cnt  <= CW'(1);
        da   <= {{(8*NBYTES-8){1'b0}}, data};
        crc  <= crc_step('1, data);
      end else if (take && cnt != '0 && cnt != FULL) begin
        da[8*cnt +: 8] <= data;
        crc  <= crc_step(crc, data);
        cnt  <= cnt + CW'(1);
        done <= (cnt == LAST);
      end
    end
  end

endmodule

// File: rtl/rxf_perfect_match.sv
module rxf_perfect_match #(
  parameter int NSLOT = 16
) (
  input  logic [47:0]             da,
  input  logic [NSLOT-1:0][47:0]  slot_addr,
  input  logic [NSLOT-1:0]        slot_en,
  output logic                    hit
);

  logic [NSLOT-1:0] eq;

  for (genvar n = 0; n < NSLOT; n++) begin : g_cmp
    assign eq[n] = slot_en[n] && (slot_addr[n] == da);
  end

  assign hit = |eq;

endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter
  import rxf_pkg::*;
#(
  parameter int NSLOT  = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic              s_sof,
  input  logic [7:0]        s_data,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic              dec_valid,
  output logic              dec_accept
);

  localparam int NBYTES = 6;
  localparam int IDX_W  = 6;

  filt_ctrl_t              ctrl;
  logic [31:0]             hash_lo, hash_hi;
  logic [NSLOT-1:0][47:0]  slot_addr;
  logic [NSLOT-1:0]        slot_en;
  logic [8*NBYTES-1:0]     da;
  logic [31:0]             crc;
  logic                    done;
  logic                    hit;
  logic [IDX_W-1:0]        hidx;
  logic                    hbit, bcast, mcast, verdict;
  logic                    sof_take;

  assign s_ready  = 1'b1;
  assign sof_take = s_valid && s_sof;

  rxf_cfg_bank #(.NSLOT(NSLOT), .ADDR_W(ADDR_W)) u_cfg (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata,
    .ctrl, .hash_lo, .hash_hi, .slot_addr, .slot_en
  );

  rxf_da_capture #(.NBYTES(NBYTES)) u_cap (
    .clk, .rst_n, .take(s_valid), .sof(s_sof), .data(s_data),
    .da, .crc, .done
  );

  rxf_perfect_match #(.NSLOT(NSLOT)) u_pm (
    .da, .slot_addr, .slot_en, .hit
  );

  // index = top bits of bitrev(~crc): index bit (IDX_W-1-k) is ~crc[k]
  always_comb begin
    for (int k = 0; k < IDX_W; k++) hidx[IDX_W-1-k] = ~crc[k];
  end

  assign hbit    = hidx[IDX_W-1] ? hash_hi[hidx[4:0]] : hash_lo[hidx[4:0]];
  assign bcast   = &da;
  assign mcast   = da[0];
  assign verdict = ctrl.rx_all | ctrl.promisc | bcast |
                   (mcast ? (ctrl.pass_mc | (ctrl.hash_mc & hbit)) : hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else if (sof_take) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid <= done;
      if (done) dec_accept <= verdict;
    end
  end

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker
  import rxf_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        s_valid,
  input logic        s_sof,
  input logic        dec_valid,
  input logic        dec_accept,
  input filt_ctrl_t  ctrl,
  input logic [47:0] da,
  input logic        hit
);

  // R2: decision strobe lasts a single cycle
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);

  // R3: level only moves with a decision or after a frame start
  a_r3_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dec_accept) |-> (dec_valid || $past(s_valid && s_sof)));

  // R3: frame start clears the level
  a_r3_sof_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_sof) |=> (!dec_accept && !dec_valid));

  // R4: promiscuous accepts
  a_r4_promisc: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(ctrl.promisc)) |-> dec_accept);

  // R5: receive-all accepts
  a_r5_rx_all: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(ctrl.rx_all)) |-> dec_accept);

  // R6: broadcast accepts
  a_r6_bcast: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(&da)) |-> dec_accept);

  // R9: unmatched unicast is dropped when no override is active
  a_r9_uc_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(!da[0] && !hit && !ctrl.promisc && !ctrl.rx_all)) |-> !dec_accept);

endmodule

bind rx_da_filter rxf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_sof(s_sof),
  .dec_valid(dec_valid), .dec_accept(dec_accept),
  .ctrl(ctrl), .da(da), .hit(hit)
);

// File: tb/tb_rx_da_filter.sv
module tb_rx_da_filter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic        s_sof = 1'b0;
  logic [7:0]  s_data = '0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        dec_valid, dec_accept;

  int tests = 0, fails = 0, cyc = 0;
  string cur_req = "R10";
  bit done_flag = 0;

  always #2 clk = ~clk;  // 250 MHz

  rx_da_filter dut (
    .clk, .rst_n, .s_valid, .s_ready, .s_sof, .s_data,
    .cfg_we, .cfg_addr, .cfg_wdata, .dec_valid, .dec_accept
  );

  // ---------------- reference model ----------------
  logic [31:0] m_ctrl, m_hlo, m_hhi;
  logic [31:0] m_slo [16];
  logic [31:0] m_shi [16];
  logic [7:0]  m_db [6];
  int          m_cnt;
  bit          m_pend, m_valid, m_acc;

  function automatic int hash_index(input logic [47:0] a);
    logic [31:0] c, inv, rev;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < 48; i++) begin
      bit fb;
      fb = c[0] ^ a[i];
      c = c >> 1;
      if (fb) c = c ^ 32'hEDB8_8320;
    end
    inv = ~c;
    for (int k = 0; k < 32; k++) rev[31-k] = inv[k];
    return int'(rev[31:26]);
  endfunction

  function automatic bit model_decide();
    logic [47:0] a;
    int idx;
    bit hb;
    for (int i = 0; i < 6; i++) a[8*i +: 8] = m_db[i];
    if (m_ctrl[3] || m_ctrl[0]) return 1;
    if (a == 48'hFFFF_FFFF_FFFF) return 1;
    if (a[0]) begin
      if (m_ctrl[1]) return 1;
      idx = hash_index(a);
      hb = (idx >= 32) ? m_hhi[idx-32] : m_hlo[idx];
      return m_ctrl[2] && hb;
    end
    for (int n = 0; n < 16; n++)
      if (m_shi[n][31] && {m_shi[n][15:0], m_slo[n]} == a) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_hlo = 0; m_hhi = 0;
      for (int n = 0; n < 16; n++) begin m_slo[n] = 0; m_shi[n] = 0; end
      for (int i = 0; i < 6; i++) m_db[i] = 0;
      m_cnt = 0; m_pend = 0; m_valid = 0; m_acc = 0;
    end else begin
      bit v;
      v = 0;
      if (s_valid && s_sof) begin
        m_acc = 0; m_pend = 0; m_cnt = 1; m_db[0] = s_data;
        for (int i = 1; i < 6; i++) m_db[i] = 0;
      end else begin
        if (m_pend) begin v = 1; m_acc = model_decide(); m_pend = 0; end
        if (s_valid && m_cnt > 0 && m_cnt < 6) begin
          m_db[m_cnt] = s_data;
          m_cnt++;
          if (m_cnt == 6) m_pend = 1;
        end
      end
      m_valid = v;
      if (cfg_we) begin
        if (cfg_addr == 6'h00) m_ctrl = {28'b0, cfg_wdata[3:0]};
        else if (cfg_addr == 6'h01) m_hlo = cfg_wdata;
        else if (cfg_addr == 6'h02) m_hhi = cfg_wdata;
        else if (cfg_addr >= 6'h10 && cfg_addr < 6'h30) begin
          if (cfg_addr[0]) m_shi[(cfg_addr - 6'h10) >> 1] = cfg_wdata;
          else             m_slo[(cfg_addr - 6'h10) >> 1] = cfg_wdata;
        end
      end
    end
  end

  // ---------------- per-cycle compare ----------------
  always @(negedge clk) begin
    if (!done_flag) begin
      tests++;
      if (dec_valid !== m_valid || dec_accept !== m_acc) begin
        fails++;
        $display("FAIL %s cycle %0d: valid/accept got %b/%b expected %b/%b",
                 cur_req, cyc, dec_valid, dec_accept, m_valid, m_acc);
      end
      tests++;
      if (s_ready !== 1'b1) begin  // R1
        fails++;
        $display("FAIL R1 cycle %0d: s_ready got %b expected 1", cyc, s_ready);
      end
    end
  end

  task automatic finish_run();
    done_flag = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done_flag) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic put(input logic [7:0] d, input bit sof);
    s_valid = 1; s_sof = sof; s_data = d;
    @(negedge clk);
    s_valid = 0; s_sof = 0;
  endtask

  task automatic send(input logic [47:0] a, input bit gaps, input int extra);
    for (int i = 0; i < 6; i++) begin
      put(a[8*i +: 8], i == 0);
      if (gaps) idle(1);
    end
    for (int i = 0; i < extra; i++) put(8'hA5 ^ 8'(i), 0);
  endtask

  task automatic set_slot(input int n, input logic [47:0] a, input bit en);
    wr(6'(16 + 2*n), a[31:0]);
    wr(6'(17 + 2*n), {en, 15'b0, a[47:32]});
  endtask

  logic [47:0] uc_a = 48'h5544_3322_1100;
  logic [47:0] uc_b = 48'h0BAD_CAFE_0002;
  logic [47:0] mc_lo, mc_hi;

  initial begin
    idle(3);
    rst_n = 1;
    cur_req = "R10"; idle(3);
    send(uc_a, 0, 0); idle(4);                     // R10: no slots -> drop

    cur_req = "R9";
    set_slot(0, uc_a, 1);
    send(uc_a, 0, 0); idle(4);                     // accept
    send(uc_b, 0, 0); idle(4);                     // drop
    set_slot(15, uc_b, 0);
    send(uc_b, 0, 0); idle(4);                     // disabled -> drop
    set_slot(15, uc_b, 1);
    send(uc_b, 1, 0); idle(4);                     // slot 15 -> accept

    cur_req = "R1";
    send(uc_a, 1, 3); idle(4);                     // gaps, extra bytes
    put(8'h77, 1); put(8'h01, 0); put(8'h02, 0);   // restart mid-frame
    send(uc_a, 0, 0); idle(4);

    cur_req = "R6";
    wr(6'h00, 0);
    send(48'hFFFF_FFFF_FFFF, 0, 0); idle(4);

    cur_req = "R7";
    for (int k = 0; k < 128; k++) begin
      logic [47:0] c;
      c = {40'h12_3456_789A, 8'(2*k + 1)};
      if (hash_index(c) >= 32) mc_hi = c; else mc_lo = c;
    end
    send(mc_lo, 0, 0); idle(4);                    // no mode -> drop
    wr(6'h00, 32'h2);
    send(mc_lo, 0, 0); idle(4);                    // pass-all -> accept

    cur_req = "R8";
    wr(6'h00, 32'h4);
    send(mc_lo, 0, 0); idle(4);                    // bit clear -> drop
    wr(6'h01, 32'h1 << hash_index(mc_lo));
    send(mc_lo, 0, 0); idle(4);                    // low word -> accept
    send(mc_hi, 0, 0); idle(4);                    // high word empty -> drop
    wr(6'h02, 32'h1 << (hash_index(mc_hi) - 32));
    send(mc_hi, 1, 0); idle(4);                    // accept
    wr(6'h01, 0);
    send(mc_lo, 0, 0); idle(4);                    // drop

    cur_req = "R4";
    wr(6'h00, 32'h1);
    send(48'h0000_1111_2222, 0, 0); idle(4);
    send(mc_lo, 0, 0); idle(4);

    cur_req = "R5";
    wr(6'h00, 32'h8);
    send(48'h0000_9999_8888, 0, 0); idle(4);

    cur_req = "R2";
    wr(6'h00, 0);
    send(uc_a, 0, 0);
    send(uc_a, 0, 0); idle(4);                     // back to back frames

    cur_req = "R3";
    send(uc_a, 0, 0);                              // sof lands on decide edge
    send(uc_b, 0, 0); idle(4);
    send(uc_a, 0, 0); idle(2);
    put(8'h10, 1); idle(3);                        // level cleared

    cur_req = "R11";
    send(48'h0000_4444_5566, 0, 0);
    wr(6'h00, 32'h1);                              // write on decide edge
    idle(3);
    send(48'h0000_4444_5566, 0, 0); idle(4);

    finish_run();
  end

endmodule